// File: doc/BRIEF.md
# Reset Clock Startup Sequencer

This block keeps the device in reset after any reset event and lets it go only once the supply is good and the chosen clock source has settled. Reset events fall into two kinds. Power-on and brown-out are cold: the active clock selection is reloaded from the configuration inputs. Every other source, such as a watchdog, the external pin or a software reset instruction, is warm: the active selection stays as it was.

After the supply-good flag is seen, the block runs a chain of wait stages picked by the active clock selection. The first stage is always a fixed startup delay. Crystal-based sources then count rising edges of the oscillator input. Modes with a PLL then wait a fixed lock time. The delay and lock lengths are parameters in system-clock cycles. The edge count is a parameter that defaults to 1024. A 3-bit stage output lets a system or a bench follow the progress of the sequence.

Clock selection codes: 0 fast RC, 1 fast RC with PLL, 2 primary, 3 primary with PLL, 4 secondary crystal, 5 low-power RC, 6 fast RC divided by 16, 7 fast RC divided by N. For the primary codes, `cfgXtal` set to 1 means a crystal (XT/HS) and set to 0 means an external clock (EC).

Top module: `clk_start_seq`

## Requirements
- R1: A pulse on `porEvt` or `borEvt` is a cold reset. When the sequence leaves idle, `actSel` takes `cfgOsc` and the stored crystal flag takes `cfgXtal`.
- R2: A pulse on any bit of `warmEvt` is a warm reset. `actSel` and the stored crystal flag keep their values, whatever the configuration inputs hold.
- R3: While any reset event is asserted, the cycle after it has `stage` = 0 (idle) and `sysRstHold` = 1. After that the block waits in stage 1 for as long as `supplyOk` is 0.
- R4: `sysRstHold` is 0 exactly when `stage` = 5 (released) and is 1 in every other stage.
- R5: Stage codes are 0 idle, 1 supply wait, 2 startup delay, 3 oscillator timer, 4 PLL lock, 5 released. With no new event the code never decreases.
- R6: Every sequence passes through stage 2, which lasts exactly `DLY_CYC` clock cycles.
- R7: Stage 3 ends after `OST_EDGES` rising edges of `oscIn`, counted after a two-flop synchronizer. It runs only for codes 2 and 3 with the crystal flag at 1, and for code 4.
- R8: Stage 4 lasts exactly `LOCK_CYC` cycles. It runs only for codes 1 and 3.
- R9: Stage paths by code: 0, 5, 6, 7 and 2 with external clock use delay only. Code 1 and code 3 with external clock use delay then lock. Code 2 with crystal and code 4 use delay then timer. Code 3 with crystal uses delay, timer, then lock.
- R10: A reset event arriving in any stage, including mid-count, returns the sequence to idle, and the sequence then runs in full from the startup delay.
- R11: Deasserting the block reset `rstN` is handled as a cold reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Block reset, active low, asynchronous |
| porEvt | input | 1 | Power-on reset event (cold) |
| borEvt | input | 1 | Brown-out reset event (cold) |
| warmEvt | input | WARM_N | Other reset sources (warm) |
| supplyOk | input | 1 | Supply stable flag |
| cfgOsc | input | 3 | Configured clock selection code |
| cfgXtal | input | 1 | Primary source is a crystal (1) or external clock (0) |
| oscIn | input | 1 | Oscillator clock, sampled for rising edges |
| sysRstHold | output | 1 | Held reset to the rest of the device |
| actSel | output | 3 | Active clock selection code |
| stage | output | 3 | Current sequence stage |

## Verification
The bench walks all sixteen combinations of selection code and crystal flag through a cold start. For each one it checks the stage path and the length of each stage, so a mode table with one wrong entry shows up as a missing or extra timer or lock stage. A directed warm reset after the configuration inputs have changed catches a design that reloads the selection on every reset. A brown-out afterwards catches one that never reloads it. A reset event injected during the lock wait must return the sequence to idle and restart a full delay; a counter that is not cleared on restart gives a short stage. Holding `supplyOk` low checks that the design does not leave the supply wait early.

// File: rtl/csq_pkg.sv
package csq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SUP  = 3'd1,
    ST_DLY  = 3'd2,
    ST_OST  = 3'd3,
    ST_LOCK = 3'd4,
    ST_RUN  = 3'd5
  } stage_e;

  localparam logic [2:0] SEL_FRC    = 3'd0;
  localparam logic [2:0] SEL_FRCPLL = 3'd1;
  localparam logic [2:0] SEL_PRI    = 3'd2;
  localparam logic [2:0] SEL_PRIPLL = 3'd3;
  localparam logic [2:0] SEL_SOSC   = 3'd4;
  localparam logic [2:0] SEL_LPRC   = 3'd5;
  localparam logic [2:0] SEL_FRCD16 = 3'd6;
  localparam logic [2:0] SEL_FRCDN  = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cycTick;
    logic edgeTick;
    logic selLoad;
  } ctl_t;

  function automatic logic needsOst(logic [2:0] sel, logic xtal);
    case (sel)
      SEL_PRI, SEL_PRIPLL: return xtal;
      SEL_SOSC:            return 1'b1;
      default:             return 1'b0;
    endcase
  endfunction

  function automatic logic needsLock(logic [2:0] sel);
    return (sel == SEL_FRCPLL) || (sel == SEL_PRIPLL);
  endfunction

endpackage

// File: rtl/csq_dpath.sv
module csq_dpath
  import csq_pkg::*;
#(
  parameter int DLY_CYC   = 44,
  parameter int OST_EDGES = 1024,
  parameter int LOCK_CYC  = 60000,
  parameter int SYNC_N    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctl_t       ctl,
  input  logic       oscIn,
  input  logic [2:0] cfgOsc,
  input  logic       cfgXtal,
  output logic [2:0] actSel,
  output logic       needOst,
  output logic       needLock,
  output logic       dlyHit,
  output logic       ostHit,
  output logic       lockHit
);
  localparam int MAX_A = (DLY_CYC > OST_EDGES) ? DLY_CYC : OST_EDGES;
  localparam int MAXC  = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
  localparam int CW    = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] DLY_LAST  = CW'(DLY_CYC - 1);
  localparam logic [CW-1:0] OST_LAST  = CW'(OST_EDGES - 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYC - 1);

  logic [SYNC_N-1:0] oscSync;
  logic              oscPrev;
  logic              oscRise;
  logic [CW-1:0]     cnt;
  logic              xtalQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscSync <= '0;
      oscPrev <= 1'b0;
    end else begin
      oscSync <= {oscSync[SYNC_N-2:0], oscIn};
      oscPrev <= oscSync[SYNC_N-1];
    end
  end

  assign oscRise = oscSync[SYNC_N-1] & ~oscPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.cntClr) begin
      cnt <= '0;
    end else if (ctl.cycTick || (ctl.edgeTick && oscRise)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSel <= SEL_FRC;
      xtalQ  <= 1'b0;
    end else if (ctl.selLoad) begin
      actSel <= cfgOsc;
      xtalQ  <= cfgXtal;
    end
  end

  assign needOst  = needsOst(actSel, xtalQ);
  assign needLock = needsLock(actSel);
  assign dlyHit   = (cnt == DLY_LAST);
  assign ostHit   = oscRise && (cnt == OST_LAST);
  assign lockHit  = (cnt == LOCK_LAST);
endmodule

// File: rtl/csq_ctrl.sv
module csq_ctrl
  import csq_pkg::*;
#(
  parameter int WARM_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porEvt,
  input  logic              borEvt,
  input  logic [WARM_N-1:0] warmEvt,
  input  logic              supplyOk,
  input  logic              needOst,
  input  logic              needLock,
  input  logic              dlyHit,
  input  logic              ostHit,
  input  logic              lockHit,
  output ctl_t              ctl,
  output stage_e            stage
);
  stage_e stNext;
  logic   coldPend;
  logic   coldEvt;
  logic   anyEvt;

  assign coldEvt = porEvt | borEvt;
  assign anyEvt  = coldEvt | (|warmEvt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            coldPend <= 1'b1;
    else if (coldEvt)     coldPend <= 1'b1;
    else if (ctl.selLoad) coldPend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= ST_IDLE;
    else       stage <= stNext;
  end

  always_comb begin
    stNext = stage;
    ctl    = '0;
    if (anyEvt) begin
      stNext     = ST_IDLE;
      ctl.cntClr = 1'b1;
    end else begin
      case (stage)
        ST_IDLE: begin
          ctl.cntClr  = 1'b1;
          ctl.selLoad = coldPend;
          stNext      = ST_SUP;
        end
        ST_SUP: begin
          ctl.cntClr = 1'b1;
          if (supplyOk) stNext = ST_DLY;
        end
        ST_DLY: begin
          if (dlyHit) begin
            ctl.cntClr = 1'b1;
            stNext = needOst ? ST_OST : (needLock ? ST_LOCK : ST_RUN);
          end else begin
            ctl.cycTick = 1'b1;
          end
        end
        ST_OST: begin
          if (ostHit) begin
            ctl.cntClr = 1'b1;
            stNext = needLock ? ST_LOCK : ST_RUN;
          end else begin
            ctl.edgeTick = 1'b1;
          end
        end
        ST_LOCK: begin
          if (lockHit) begin
            ctl.cntClr = 1'b1;
            stNext = ST_RUN;
          end else begin
            ctl.cycTick = 1'b1;
          end
        end
        default: begin
          ctl.cntClr = 1'b1;
          stNext     = ST_RUN;
        end
      endcase
    end
  end
endmodule

// File: rtl/clk_start_seq.sv
module clk_start_seq
  import csq_pkg::*;
#(
  parameter int WARM_N    = 2,
  parameter int DLY_CYC   = 44,
  parameter int OST_EDGES = 1024,
  parameter int LOCK_CYC  = 60000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porEvt,
  input  logic              borEvt,
  input  logic [WARM_N-1:0] warmEvt,
  input  logic              supplyOk,
  input  logic [2:0]        cfgOsc,
  input  logic              cfgXtal,
  input  logic              oscIn,
  output logic              sysRstHold,
  output logic [2:0]        actSel,
  output logic [2:0]        stage
);
  ctl_t   ctl;
  stage_e stageQ;
  logic   needOst, needLock, dlyHit, ostHit, lockHit;

  csq_ctrl #(.WARM_N(WARM_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .porEvt(porEvt), .borEvt(borEvt),
    .warmEvt(warmEvt), .supplyOk(supplyOk), .needOst(needOst),
    .needLock(needLock), .dlyHit(dlyHit), .ostHit(ostHit),
    .lockHit(lockHit), .ctl(ctl), .stage(stageQ)
  );

  csq_dpath #(
    .DLY_CYC(DLY_CYC), .OST_EDGES(OST_EDGES), .LOCK_CYC(LOCK_CYC), .SYNC_N(2)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .oscIn(oscIn), .cfgOsc(cfgOsc),
    .cfgXtal(cfgXtal), .actSel(actSel), .needOst(needOst),
    .needLock(needLock), .dlyHit(dlyHit), .ostHit(ostHit), .lockHit(lockHit)
  );

  assign stage      = stageQ;
  assign sysRstHold = (stageQ != ST_RUN);
endmodule

// File: rtl/clk_start_seq_chk.sv
module clk_start_seq_chk #(
  parameter int WARM_N = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              porEvt,
  input logic              borEvt,
  input logic [WARM_N-1:0] warmEvt,
  input logic              supplyOk,
  input logic              sysRstHold,
  input logic [2:0]        actSel,
  input logic [2:0]        stage
);
  // R3
  evt_forces_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (porEvt || borEvt || (|warmEvt)) |=> (stage == 3'd0) && sysRstHold);

  // R3
  supply_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stage == 3'd1) && !supplyOk |=> (stage == 3'd1) || (stage == 3'd0));

  // R4
  release_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysRstHold) |-> (stage == 3'd5) && ($past(stage) != 3'd5));

  // R5
  stage_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    stage <= 3'd5);

  // R5
  stage_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stage != $past(stage)) && (stage != 3'd0) |-> (stage > $past(stage)));

  // R1
  sel_moves_at_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actSel != $past(actSel)) |-> ($past(stage) == 3'd0));

  // R7
  ost_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stage == 3'd3) |-> (actSel == 3'd2 || actSel == 3'd3 || actSel == 3'd4));

  // R8
  lock_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stage == 3'd4) |-> (actSel == 3'd1 || actSel == 3'd3));
endmodule

bind clk_start_seq clk_start_seq_chk #(.WARM_N(WARM_N)) u_chk (
  .clk(clk), .rstN(rstN), .porEvt(porEvt), .borEvt(borEvt),
  .warmEvt(warmEvt), .supplyOk(supplyOk), .sysRstHold(sysRstHold),
  .actSel(actSel), .stage(stage)
);

// File: tb/clk_start_seq_tb.sv
`timescale 1ns/1ps
module clk_start_seq_tb;
  localparam int DLY  = 6;
  localparam int OSTN = 1024;
  localparam int LCK  = 40;

  logic clk = 0, rstN = 0, porEvt = 0, borEvt = 0, supplyOk = 0;
  logic [1:0] warmEvt = '0;
  logic [2:0] cfgOsc = 3'd3;
  logic cfgXtal = 1'b0, oscIn = 1'b0;
  logic sysRstHold;
  logic [2:0] actSel, stage;

  int total = 0, bad = 0, cyc = 0;
  bit doneFlag = 0;

  // {sel, xtal, expOst, expLock}
  localparam logic [5:0] VEC [16] = '{
    {3'd0,1'b0,1'b0,1'b0}, {3'd0,1'b1,1'b0,1'b0},
    {3'd1,1'b0,1'b0,1'b1}, {3'd1,1'b1,1'b0,1'b1},
    {3'd2,1'b0,1'b0,1'b0}, {3'd2,1'b1,1'b1,1'b0},
    {3'd3,1'b0,1'b0,1'b1}, {3'd3,1'b1,1'b1,1'b1},
    {3'd4,1'b0,1'b1,1'b0}, {3'd4,1'b1,1'b1,1'b0},
    {3'd5,1'b0,1'b0,1'b0}, {3'd5,1'b1,1'b0,1'b0},
    {3'd6,1'b0,1'b0,1'b0}, {3'd6,1'b1,1'b0,1'b0},
    {3'd7,1'b0,1'b0,1'b0}, {3'd7,1'b1,1'b0,1'b0}
  };

  clk_start_seq #(.WARM_N(2), .DLY_CYC(DLY), .OST_EDGES(OSTN), .LOCK_CYC(LCK)) u_dut (
    .clk(clk), .rstN(rstN), .porEvt(porEvt), .borEvt(borEvt), .warmEvt(warmEvt),
    .supplyOk(supplyOk), .cfgOsc(cfgOsc), .cfgXtal(cfgXtal), .oscIn(oscIn),
    .sysRstHold(sysRstHold), .actSel(actSel), .stage(stage)
  );

  always #5 clk = ~clk;
  always @(negedge clk) oscIn <= ~oscIn;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !doneFlag) begin
      doneFlag = 1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int which, input int n);
    @(negedge clk);
    if (which == 0) porEvt = 1;
    else if (which == 1) borEvt = 1;
    else warmEvt[which-2] = 1;
    repeat (n) @(negedge clk);
    porEvt = 0; borEvt = 0; warmEvt = '0;
  endtask

  int nDly, nOst, nLck;
  bit orderOk, holdOk, gotRun;

  task automatic runSeq();
    int prev;
    prev = 0; nDly = 0; nOst = 0; nLck = 0;
    orderOk = 1; holdOk = 1; gotRun = 0;
    for (int k = 0; k < 6000; k++) begin
      @(posedge clk); #1;
      if (stage < prev[2:0]) orderOk = 0;
      if (sysRstHold != (stage != 3'd5)) holdOk = 0;
      if (stage == 3'd2) nDly++;
      if (stage == 3'd3) nOst++;
      if (stage == 3'd4) nLck++;
      prev = int'(stage);
      if (stage == 3'd5) begin gotRun = 1; break; end
    end
  endtask

  initial begin
    // R11 R3 reset state
    repeat (3) @(negedge clk);
    chk(stage == 3'd0, "R3 reset stage", stage, 0);
    chk(sysRstHold == 1'b1, "R3 reset hold", sysRstHold, 1);
    rstN = 1;
    repeat (20) @(negedge clk);
    chk(stage == 3'd1, "R3 supply wait", stage, 1);
    chk(sysRstHold == 1'b1, "R3 hold while supply low", sysRstHold, 1);
    chk(actSel == 3'd3, "R11 cold load after rstN", actSel, 3);
    supplyOk = 1;
    runSeq();
    chk(gotRun, "R4 released after rstN", gotRun, 1);

    // table walk: cold start per mode (R1 R5 R6 R7 R8 R9)
    for (int i = 0; i < 16; i++) begin
      cfgOsc  = VEC[i][5:3];
      cfgXtal = VEC[i][2];
      pulse(0, 3);
      runSeq();
      chk(actSel == VEC[i][5:3], "R1 cold sel", actSel, VEC[i][5:3]);
      chk(gotRun && holdOk, "R4 release/hold", holdOk, 1);
      chk(orderOk, "R5 stage order", orderOk, 1);
      chk(nDly == DLY, "R6 delay length", nDly, DLY);
      chk((nOst != 0) == VEC[i][1], "R9 timer stage presence", nOst, VEC[i][1]);
      if (VEC[i][1])
        chk(nOst >= 2*OSTN-2 && nOst <= 2*OSTN+2, "R7 timer edges", nOst, 2*OSTN);
      chk((nLck != 0) == VEC[i][0], "R9 lock stage presence", nLck, VEC[i][0]);
      if (VEC[i][0]) chk(nLck == LCK, "R8 lock length", nLck, LCK);
    end

    // R2 warm keeps selection
    cfgOsc = 3'd3; cfgXtal = 1'b1;
    pulse(0, 2); runSeq();
    cfgOsc = 3'd5; cfgXtal = 1'b0;
    pulse(3, 2); runSeq();
    chk(actSel == 3'd3, "R2 warm keeps sel", actSel, 3);
    chk(nOst != 0 && nLck == LCK, "R2 warm keeps crystal path", nLck, LCK);

    // R1 brown-out reloads
    pulse(1, 1); runSeq();
    chk(actSel == 3'd5, "R1 bor reload", actSel, 5);
    chk(nOst == 0 && nLck == 0, "R1 bor path", nOst + nLck, 0);

    // R10 restart during lock
    cfgOsc = 3'd1;
    pulse(0, 1);
    for (int k = 0; k < 200 && stage != 3'd4; k++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(stage == 3'd4, "R10 in lock before event", stage, 4);
    warmEvt[0] = 1;
    @(posedge clk); #1;
    chk(stage == 3'd0 && sysRstHold, "R10 back to idle", stage, 0);
    @(negedge clk); warmEvt = '0;
    runSeq();
    chk(nDly == DLY, "R10 full delay after restart", nDly, DLY);
    chk(nLck == LCK, "R10 full lock after restart", nLck, LCK);

    // R3 held event and supply wait
    supplyOk = 0;
    @(negedge clk); porEvt = 1;
    repeat (10) @(negedge clk);
    chk(stage == 3'd0 && sysRstHold, "R3 held event idle", stage, 0);
    porEvt = 0;
    repeat (30) @(negedge clk);
    chk(stage == 3'd1 && sysRstHold, "R3 waits for supply", stage, 1);
    supplyOk = 1;
    runSeq();
    chk(gotRun && nDly == DLY, "R3 release after supply", nDly, DLY);

    if (!doneFlag) begin
      doneFlag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule